// File: doc/BRIEF.md
# Speculative Transactional Cache Set Controller

This block holds one set of a four-way write-back data cache and adds hardware transactional memory state to it. Besides valid and dirty bits, every way carries a speculative-read mark and a speculative-write mark. The core issues transaction begin, load, store, transaction end and explicit abort requests. Other agents send snoops (read or write) that are checked against the set.

Inside a transaction, loads mark lines as read and stores mark lines as written. Written data stays hidden from snoops until the outermost end commits. A snoop that touches a written line, or a snoop write that touches a read line, aborts the transaction with a conflict cause. When a new line is needed and only speculative lines remain, the transaction aborts with an overflow cause. An abort invalidates every speculatively written line. If a line was dirty before the transaction, its committed value is written back before the first speculative write lands on it.

Outside a transaction the set behaves as a plain write-back set. Each request is handled in one cycle, and all results appear on registered outputs one cycle after the request.

Top module: `stc_set_ctrl`

## Requirements
- R1: After reset all ways are invalid, no transaction is active, and every output pulse is low. A first load therefore misses.
- R2: Load and store requests produce `rsp_valid` one cycle later. A load returns the line data on a hit, or `fill_data` on a miss. A miss allocates a clean line. A store writes `req_wdata` into the line, marks it dirty and returns zero data. Request codes: 1 begin, 2 load, 3 store, 4 end, 5 abort.
- R3: Victim choice on a miss follows a fixed order. Invalid ways come first, then valid clean unmarked ways, then valid dirty unmarked ways, each taking the lowest index. Evicting a dirty way pulses `wb_valid` with its tag and data. A way that carries a speculative mark is never chosen.
- R4: While a transaction is active, a snoop that hits a speculatively written line reports a miss (`snp_hit`=0). It also aborts the transaction with cause 1 (conflict).
- R5: A snoop write that hits a line carrying only a read mark aborts with cause 1, reports the hit and invalidates that line. A snoop read of such a line reports the hit and does not abort.
- R6: Inside a transaction, the first store to a dirty unmarked line first writes back the old tag and data on `wb_valid`.
- R7: An end request at depth one pulses `tx_commit`, clears all marks and leaves the written lines dirty and visible to snoops.
- R8: Every abort pulses `tx_abort`, invalidates all speculatively written lines, drops all read marks and ends the transaction. Lines that were only read stay valid. An abort request gives cause 3 (explicit). An abort or end request with no transaction active is ignored.
- R9: A miss inside a transaction with no eligible victim aborts with cause 2 (overflow). The response then reports `rsp_hit`=0 with zero data, and the access is not performed.
- R10: Begin requests nest flatly up to a depth of 7. Only the end request that brings the depth back to zero commits.
- R11: A snoop has priority over a core request in the same cycle: `req_ready` is low, and no core response follows. A snoop write invalidates an unmarked hit line and reports its data and dirty bit; a snoop read leaves the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_op | input | 3 | Request code (1 begin, 2 load, 3 store, 4 end, 5 abort) |
| req_tag | input | TAG_W | Line tag of load or store |
| req_wdata | input | DATA_W | Store data |
| fill_data | input | DATA_W | Next-level data for a miss allocation |
| req_ready | output | 1 | Core request accepted this cycle |
| snp_valid | input | 1 | Snoop present |
| snp_write | input | 1 | Snoop is a write (invalidating) |
| snp_tag | input | TAG_W | Snooped tag |
| rsp_valid | output | 1 | Load/store response |
| rsp_hit | output | 1 | Request hit in the set |
| rsp_data | output | DATA_W | Load data |
| wb_valid | output | 1 | Writeback to next level |
| wb_tag | output | TAG_W | Writeback tag |
| wb_data | output | DATA_W | Writeback data |
| snp_rsp_valid | output | 1 | Snoop response |
| snp_hit | output | 1 | Snoop found a visible line |
| snp_dirty | output | 1 | Snooped line was dirty |
| snp_data | output | DATA_W | Snooped line data |
| tx_active | output | 1 | Transaction depth non-zero |
| tx_commit | output | 1 | Commit pulse |
| tx_abort | output | 1 | Abort pulse |
| abort_cause | output | 2 | 0 none, 1 conflict, 2 overflow, 3 explicit |

## Verification
The bench builds the block with WAYS=4, TAG_W=8, DATA_W=16 and DEPTH_W=3. Random tags are drawn from only eight values, so a four-way set fills quickly. This makes dirty evictions, overflow aborts and snoop conflicts frequent under random traffic. The three-bit depth makes the nesting limit of 7 reachable within a short run. Directed sequences cover the single-cycle cases: a writeback of a dirty line before its first speculative store, a read-marked line under both kinds of snoop, and a fifth line in one transaction.

// File: rtl/stc_pkg.sv
package stc_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_BEGIN = 3'd1,
        OP_LOAD  = 3'd2,
        OP_STORE = 3'd3,
        OP_END   = 3'd4,
        OP_ABORT = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_CONFLICT = 2'd1,
        CAUSE_OVERFLOW = 2'd2,
        CAUSE_EXPLICIT = 2'd3
    } cause_e;

    typedef struct packed {
        logic valid;
        logic dirty;
        logic rd_mark;
        logic wr_mark;
    } line_flags_t;

    function automatic logic is_spec(line_flags_t f);
        return f.rd_mark | f.wr_mark;
    endfunction

endpackage

// File: rtl/stc_lookup.sv
module stc_lookup #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    parameter int IDX_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           key,
    output logic                       hit,
    output logic [IDX_W-1:0]           way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == key);
    end

    always_comb begin
        hit = |match;
        way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i]) way = IDX_W'(i);
        end
    end
endmodule

// File: rtl/stc_victim.sv
module stc_victim
    import stc_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int IDX_W = $clog2(WAYS)
) (
    input  line_flags_t        flags [WAYS],
    output logic               found,
    output logic [IDX_W-1:0]   way
);
    logic [WAYS-1:0] empty_v, clean_v, dirty_v, pool;

    for (genvar w = 0; w < WAYS; w++) begin : g_class
        assign empty_v[w] = !flags[w].valid;
        assign clean_v[w] = flags[w].valid && !flags[w].dirty && !is_spec(flags[w]);
        assign dirty_v[w] = flags[w].valid &&  flags[w].dirty && !is_spec(flags[w]);
    end

    always_comb begin
        if (|empty_v)      pool = empty_v;
        else if (|clean_v) pool = clean_v;
        else               pool = dirty_v;
        found = |pool;
        way   = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (pool[i]) way = IDX_W'(i);
        end
    end
endmodule

// File: rtl/stc_txdepth.sv
module stc_txdepth #(
    parameter int DEPTH_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    input  logic clr,
    output logic active,
    output logic outermost
);
    localparam logic [DEPTH_W-1:0] MAX_DEPTH = '1;

    logic [DEPTH_W-1:0] depth_q;

    always_ff @(posedge clk) begin
        if (rst || clr)                         depth_q <= '0;
        else if (inc && depth_q != MAX_DEPTH)   depth_q <= depth_q + 1'b1;
        else if (dec && depth_q != '0)          depth_q <= depth_q - 1'b1;
    end

    assign active    = (depth_q != '0);
    assign outermost = (depth_q == DEPTH_W'(1));
endmodule

// File: rtl/stc_set_ctrl.sv
module stc_set_ctrl
    import stc_pkg::*;
#(
    parameter int WAYS    = 4,
    parameter int TAG_W   = 8,
    parameter int DATA_W  = 16,
    parameter int DEPTH_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] fill_data,
    output logic              req_ready,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [TAG_W-1:0]  snp_tag,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              wb_valid,
    output logic [TAG_W-1:0]  wb_tag,
    output logic [DATA_W-1:0] wb_data,
    output logic              snp_rsp_valid,
    output logic              snp_hit,
    output logic              snp_dirty,
    output logic [DATA_W-1:0] snp_data,
    output logic              tx_active,
    output logic              tx_commit,
    output logic              tx_abort,
    output logic [1:0]        abort_cause
);
    localparam int IDX_W = $clog2(WAYS);

    line_flags_t                 fl_q   [WAYS];
    line_flags_t                 fl_d   [WAYS];
    logic [WAYS-1:0][TAG_W-1:0]  tag_q, tag_d;
    logic [WAYS-1:0][DATA_W-1:0] dat_q, dat_d;
    logic [WAYS-1:0]             valid_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_vld
        assign valid_vec[w] = fl_q[w].valid;
    end

    logic             c_hit, s_hit, v_found;
    logic [IDX_W-1:0] c_way, s_way, v_way;

    stc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_core_lkp (
        .valid(valid_vec), .tags(tag_q), .key(req_tag), .hit(c_hit), .way(c_way)
    );

    stc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_snp_lkp (
        .valid(valid_vec), .tags(tag_q), .key(snp_tag), .hit(s_hit), .way(s_way)
    );

    stc_victim #(.WAYS(WAYS), .IDX_W(IDX_W)) u_victim (
        .flags(fl_q), .found(v_found), .way(v_way)
    );

    logic tx_inc, tx_dec, tx_clr, in_tx, at_outer;

    stc_txdepth #(.DEPTH_W(DEPTH_W)) u_depth (
        .clk(clk), .rst(rst), .inc(tx_inc), .dec(tx_dec), .clr(tx_clr),
        .active(in_tx), .outermost(at_outer)
    );

    // next-state outputs
    logic              rsp_valid_d, rsp_hit_d, wb_valid_d;
    logic [DATA_W-1:0] rsp_data_d, wb_data_d, snp_data_d;
    logic [TAG_W-1:0]  wb_tag_d;
    logic              snp_rsp_d, snp_hit_d, snp_dirty_d, commit_d, kill;
    cause_e            cause_d;
    op_e               op;
    line_flags_t       lf;
    logic [IDX_W-1:0]  tw;

    assign req_ready = !snp_valid;
    assign op        = op_e'(req_op);

    always_comb begin
        for (int i = 0; i < WAYS; i++) fl_d[i] = fl_q[i];
        tag_d       = tag_q;
        dat_d       = dat_q;
        rsp_valid_d = 1'b0;
        rsp_hit_d   = 1'b0;
        rsp_data_d  = '0;
        wb_valid_d  = 1'b0;
        wb_tag_d    = '0;
        wb_data_d   = '0;
        snp_rsp_d   = 1'b0;
        snp_hit_d   = 1'b0;
        snp_dirty_d = 1'b0;
        snp_data_d  = '0;
        commit_d    = 1'b0;
        kill        = 1'b0;
        cause_d     = CAUSE_NONE;
        tx_inc      = 1'b0;
        tx_dec      = 1'b0;
        lf          = '0;
        tw          = '0;

        if (snp_valid) begin
            snp_rsp_d = 1'b1;
            if (s_hit) begin
                lf = fl_q[s_way];
                if (lf.wr_mark || (snp_write && lf.rd_mark)) begin
                    kill    = 1'b1;
                    cause_d = CAUSE_CONFLICT;
                end
                if (!lf.wr_mark) begin
                    snp_hit_d   = 1'b1;
                    snp_dirty_d = lf.dirty;
                    snp_data_d  = dat_q[s_way];
                    if (snp_write) fl_d[s_way] = '0;
                end
            end
        end else if (req_valid) begin
            unique case (op)
                OP_BEGIN: tx_inc = 1'b1;
                OP_END: begin
                    if (in_tx) begin
                        tx_dec = 1'b1;
                        if (at_outer) begin
                            commit_d = 1'b1;
                            for (int i = 0; i < WAYS; i++) begin
                                fl_d[i].rd_mark = 1'b0;
                                fl_d[i].wr_mark = 1'b0;
                            end
                        end
                    end
                end
                OP_ABORT: begin
                    if (in_tx) begin
                        kill    = 1'b1;
                        cause_d = CAUSE_EXPLICIT;
                    end
                end
                OP_LOAD, OP_STORE: begin
                    rsp_valid_d = 1'b1;
                    if (c_hit || v_found) begin
                        if (c_hit) begin
                            tw = c_way;
                            lf = fl_q[c_way];
                            rsp_hit_d = 1'b1;
                        end else begin
                            tw = v_way;
                            if (fl_q[v_way].valid && fl_q[v_way].dirty) begin
                                wb_valid_d = 1'b1;
                                wb_tag_d   = tag_q[v_way];
                                wb_data_d  = dat_q[v_way];
                            end
                            lf         = '0;
                            lf.valid   = 1'b1;
                            tag_d[tw]  = req_tag;
                            dat_d[tw]  = fill_data;
                        end
                        if (op == OP_LOAD) begin
                            rsp_data_d = dat_d[tw];
                            if (in_tx) lf.rd_mark = 1'b1;
                        end else begin
                            if (in_tx && lf.dirty && !lf.wr_mark) begin
                                wb_valid_d = 1'b1;
                                wb_tag_d   = tag_q[tw];
                                wb_data_d  = dat_q[tw];
                            end
                            dat_d[tw] = req_wdata;
                            lf.dirty  = 1'b1;
                            if (in_tx) lf.wr_mark = 1'b1;
                        end
                        fl_d[tw] = lf;
                    end else begin
                        kill    = 1'b1;
                        cause_d = CAUSE_OVERFLOW;
                    end
                end
                default: ;
            endcase
        end

        if (kill) begin
            for (int i = 0; i < WAYS; i++) begin
                if (fl_d[i].wr_mark) fl_d[i] = '0;
                fl_d[i].rd_mark = 1'b0;
            end
        end
        tx_clr = kill;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WAYS; i++) fl_q[i] <= '0;
            tag_q         <= '0;
            dat_q         <= '0;
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_data      <= '0;
            wb_valid      <= 1'b0;
            wb_tag        <= '0;
            wb_data       <= '0;
            snp_rsp_valid <= 1'b0;
            snp_hit       <= 1'b0;
            snp_dirty     <= 1'b0;
            snp_data      <= '0;
            tx_commit     <= 1'b0;
            tx_abort      <= 1'b0;
            abort_cause   <= CAUSE_NONE;
        end else begin
            for (int i = 0; i < WAYS; i++) fl_q[i] <= fl_d[i];
            tag_q         <= tag_d;
            dat_q         <= dat_d;
            rsp_valid     <= rsp_valid_d;
            rsp_hit       <= rsp_hit_d;
            rsp_data      <= rsp_data_d;
            wb_valid      <= wb_valid_d;
            wb_tag        <= wb_tag_d;
            wb_data       <= wb_data_d;
            snp_rsp_valid <= snp_rsp_d;
            snp_hit       <= snp_hit_d;
            snp_dirty     <= snp_dirty_d;
            snp_data      <= snp_data_d;
            tx_commit     <= commit_d;
            tx_abort      <= kill;
            abort_cause   <= cause_d;
        end
    end

    assign tx_active = in_tx;
endmodule

// File: rtl/stc_set_ctrl_chk.sv
module stc_set_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       snp_valid,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic       wb_valid,
    input logic       tx_active,
    input logic       tx_commit,
    input logic       tx_abort,
    input logic [1:0] abort_cause
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!tx_active && !wb_valid && !tx_abort && !tx_commit));

    // R7
    commit_ends_tx_chk: assert property (@(posedge clk) disable iff (rst)
        tx_commit |-> (!tx_active && !tx_abort));

    // R8
    abort_ends_tx_chk: assert property (@(posedge clk) disable iff (rst)
        tx_abort |-> (!tx_active && abort_cause != 2'd0));

    // R8
    abort_needs_tx_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(tx_active) |-> !tx_abort);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_abort && abort_cause == 2'd2) |-> (rsp_valid && !rsp_hit));

    // R11
    snoop_first_chk: assert property (@(posedge clk) disable iff (rst)
        $past(snp_valid) |-> !rsp_valid);

    // R10
    one_event_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_commit, tx_abort}));
endmodule

bind stc_set_ctrl stc_set_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .snp_valid(snp_valid), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .wb_valid(wb_valid), .tx_active(tx_active),
    .tx_commit(tx_commit), .tx_abort(tx_abort), .abort_cause(abort_cause)
);

// File: tb/tb_stc_set_ctrl.sv
module tb_stc_set_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WAYS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [7:0]  req_tag = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] fill_data = '0;
    logic        req_ready;
    logic        snp_valid = 1'b0;
    logic        snp_write = 1'b0;
    logic [7:0]  snp_tag = '0;
    logic        rsp_valid, rsp_hit, wb_valid, snp_rsp_valid, snp_hit, snp_dirty;
    logic [15:0] rsp_data, wb_data, snp_data;
    logic [7:0]  wb_tag;
    logic        tx_active, tx_commit, tx_abort;
    logic [1:0]  abort_cause;

    always #(CLK_PERIOD/2) clk = ~clk;

    stc_set_ctrl #(.WAYS(WAYS), .TAG_W(8), .DATA_W(16), .DEPTH_W(3)) dut (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state
    bit          m_v [WAYS], m_d [WAYS], m_sr [WAYS], m_sw [WAYS];
    logic [7:0]  m_tag [WAYS];
    logic [15:0] m_dat [WAYS];
    int          m_depth;
    logic [15:0] wseq = 16'h1000;

    task automatic chk(string r, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    function automatic int find_tag(logic [7:0] t);
        for (int i = 0; i < WAYS; i++) if (m_v[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    function automatic int pick_victim();
        for (int i = 0; i < WAYS; i++) if (!m_v[i]) return i;
        for (int i = 0; i < WAYS; i++) if (!m_d[i] && !m_sr[i] && !m_sw[i]) return i;
        for (int i = 0; i < WAYS; i++) if (!m_sr[i] && !m_sw[i]) return i;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < WAYS; i++) begin
            m_v[i] = 0; m_d[i] = 0; m_sr[i] = 0; m_sw[i] = 0; m_tag[i] = '0; m_dat[i] = '0;
        end
        m_depth = 0;
    endtask

    task automatic step(string r, bit sv, bit swr, logic [7:0] st,
                        bit rv, logic [2:0] op, logic [7:0] tg, logic [15:0] wd,
                        logic [15:0] fd);
        int e_rv = 0, e_rh = 0, e_rd = 0, e_wv = 0, e_wt = 0, e_wd = 0;
        int e_sv = 0, e_sh = 0, e_sd = 0, e_sdat = 0, e_c = 0, e_a = 0, e_cause = 0;
        int w;
        bit kill = 0;
        if (sv) begin
            e_sv = 1;
            w = find_tag(st);
            if (w >= 0) begin
                if (m_sw[w] || (swr && m_sr[w])) begin kill = 1; e_cause = 1; end
                if (!m_sw[w]) begin
                    e_sh = 1; e_sd = m_d[w]; e_sdat = m_dat[w];
                    if (swr) begin m_v[w] = 0; m_d[w] = 0; m_sr[w] = 0; m_sw[w] = 0; end
                end
            end
        end else if (rv) begin
            case (op)
                3'd1: if (m_depth < 7) m_depth++;
                3'd4: if (m_depth > 0) begin
                    m_depth--;
                    if (m_depth == 0) begin
                        e_c = 1;
                        for (int i = 0; i < WAYS; i++) begin m_sr[i] = 0; m_sw[i] = 0; end
                    end
                end
                3'd5: if (m_depth > 0) begin kill = 1; e_cause = 3; end
                3'd2, 3'd3: begin
                    e_rv = 1;
                    w = find_tag(tg);
                    if (w >= 0) e_rh = 1;
                    else begin
                        w = pick_victim();
                        if (w >= 0) begin
                            if (m_v[w] && m_d[w]) begin e_wv = 1; e_wt = m_tag[w]; e_wd = m_dat[w]; end
                            m_v[w] = 1; m_d[w] = 0; m_sr[w] = 0; m_sw[w] = 0;
                            m_tag[w] = tg; m_dat[w] = fd;
                        end
                    end
                    if (w < 0) begin kill = 1; e_cause = 2; end
                    else if (op == 3'd2) begin
                        e_rd = m_dat[w];
                        if (m_depth > 0) m_sr[w] = 1;
                    end else begin
                        if (m_depth > 0 && m_d[w] && !m_sw[w]) begin
                            e_wv = 1; e_wt = m_tag[w]; e_wd = m_dat[w];
                        end
                        m_dat[w] = wd; m_d[w] = 1;
                        if (m_depth > 0) m_sw[w] = 1;
                    end
                end
                default: ;
            endcase
        end
        if (kill) begin
            e_a = 1;
            m_depth = 0;
            for (int i = 0; i < WAYS; i++) begin
                if (m_sw[i]) begin m_v[i] = 0; m_d[i] = 0; end
                m_sr[i] = 0; m_sw[i] = 0;
            end
        end
        snp_valid = sv; snp_write = swr; snp_tag = st;
        req_valid = rv; req_op = op; req_tag = tg; req_wdata = wd; fill_data = fd;
        #1;
        chk("R11", "req_ready", req_ready, !sv);
        @(negedge clk);
        chk(r, "rsp_valid", rsp_valid, e_rv);
        chk(r, "rsp_hit", rsp_hit, e_rh);
        chk(r, "rsp_data", rsp_data, e_rd);
        chk(r, "wb_valid", wb_valid, e_wv);
        if (e_wv != 0) begin
            chk(r, "wb_tag", wb_tag, e_wt);
            chk(r, "wb_data", wb_data, e_wd);
        end
        chk(r, "snp_rsp_valid", snp_rsp_valid, e_sv);
        chk(r, "snp_hit", snp_hit, e_sh);
        chk(r, "snp_dirty", snp_dirty, e_sd);
        chk(r, "snp_data", snp_data, e_sdat);
        chk(r, "tx_commit", tx_commit, e_c);
        chk(r, "tx_abort", tx_abort, e_a);
        chk(r, "abort_cause", abort_cause, e_cause);
        chk(r, "tx_active", tx_active, m_depth != 0);
        snp_valid = 0; req_valid = 0;
    endtask

    task automatic ld(string r, logic [7:0] t);
        step(r, 0, 0, 0, 1, 3'd2, t, 0, {8'hF0, t});
    endtask
    task automatic stv(string r, logic [7:0] t);
        wseq = wseq + 16'h0011;
        step(r, 0, 0, 0, 1, 3'd3, t, wseq, {8'hF0, t});
    endtask
    task automatic cop(string r, logic [2:0] op);
        step(r, 0, 0, 0, 1, op, 0, 0, 0);
    endtask
    task automatic snp(string r, bit wr, logic [7:0] t);
        step(r, 1, wr, t, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        model_reset();
        @(negedge clk);
    endtask

    initial begin
        model_reset();
        do_reset();
        // R1: quiet outputs after reset, first access misses
        chk("R1", "tx_active", tx_active, 0);
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "wb_valid", wb_valid, 0);
        ld("R1", 8'd5);
        // R2: plain write-back behaviour
        stv("R2", 8'd1); ld("R2", 8'd1); snp("R2", 0, 8'd1);
        ld("R2", 8'd2); ld("R2", 8'd3);
        // R3: victim order: clean first, then dirty with writeback
        ld("R3", 8'd9); stv("R3", 8'd10); stv("R3", 8'd11); stv("R3", 8'd12);
        stv("R3", 8'd13); ld("R3", 8'd14);
        // R6 then R4: dirty line written in tx, then snooped
        stv("R6", 8'd14);
        cop("R6", 3'd1); stv("R6", 8'd14); stv("R6", 8'd14);
        snp("R4", 0, 8'd14); ld("R4", 8'd14);
        // R5: read-marked line under both snoop kinds
        cop("R5", 3'd1); ld("R5", 8'd20); snp("R5", 0, 8'd20); snp("R5", 1, 8'd20);
        ld("R5", 8'd20);
        // R10 and R7: flat nesting and commit
        cop("R10", 3'd1); cop("R10", 3'd1); stv("R10", 8'd30); cop("R10", 3'd4);
        cop("R7", 3'd4); snp("R7", 0, 8'd30); cop("R8", 3'd4); cop("R8", 3'd5);
        for (int i = 0; i < 9; i++) cop("R10", 3'd1);
        for (int i = 0; i < 7; i++) cop("R10", 3'd4);
        // R8: explicit abort
        cop("R8", 3'd1); ld("R8", 8'd40); stv("R8", 8'd41); cop("R8", 3'd5);
        ld("R8", 8'd40); ld("R8", 8'd41);
        // R9: fifth speculative line
        cop("R9", 3'd1); stv("R9", 8'd50); stv("R9", 8'd51); stv("R9", 8'd52);
        stv("R9", 8'd53); ld("R9", 8'd54); ld("R9", 8'd50);
        // R11: snoop write beats a core request
        stv("R11", 8'd60);
        step("R11", 1, 1, 8'd60, 1, 3'd2, 8'd60, 0, 16'h0);
        ld("R11", 8'd60);

        // constrained random traffic
        void'($urandom(32'h5eed1234));
        for (int k = 0; k < 3000; k++) begin
            int pick = $urandom_range(0, 15);
            logic [7:0] t = 8'($urandom_range(0, 7));
            if (pick < 3) snp("R5", pick[0], t);
            else if (pick < 5) cop("R10", 3'd1);
            else if (pick < 7) cop("R7", 3'd4);
            else if (pick == 7) cop("R8", 3'd5);
            else if (pick < 12) ld("R2", t);
            else stv("R3", t);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule